// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Controller

This block runs the transmit attempts for one Ethernet frame at a time in a MAC transmit path. It works at byte rate, with one clock per byte time, so one slot of 512 bit times is `SLOT_BYTES` cycles and the interframe gap is `IPG_BYTES` cycles. It pulls frame bytes from a FIFO through a valid/ready byte stream and drives a registered transmit-enable and data byte toward the PHY. A first attempt may start only when the FIFO reports enough 64-byte cells or a whole packet.

In half-duplex mode the block watches carrier and collision. If a collision occurs while fewer than one slot of bytes has been sent, the block stops taking bytes and sends a 32-bit jam. It then waits a random number of slots drawn by truncated binary exponential back-off. After that it asks the FIFO to rewind, through a retry pulse, and sends the frame again. A collision after the first slot is ignored. After `MAX_ATT` colliding attempts the frame is dropped. In full-duplex mode the carrier and collision inputs have no effect. Each frame ends with a single status pulse that carries a class code.

Top module: `hdx_tx_ctrl`

## Requirements
- R1: A first attempt starts only while `in_valid` is high and either `pkt_complete` is high or `fifo_cells >= cell_thresh`. While neither holds, `tx_en` stays low.
- R2: `tx_en` of an attempt rises only after at least `IPG_BYTES` consecutive cycles in which `tx_en` was low and, in half duplex, `crs` was low.
- R3: A collision (`col` high in half duplex) while fewer than `SLOT_BYTES` bytes of the attempt have been taken stops byte intake. It raises `col_pulse` for one cycle. The line then carries exactly `JAM_BITS/8` (4) bytes of `JAM_BYTE` (0x55) on `tx_en`, directly after the bytes already sent.
- R4: A collision after `SLOT_BYTES` or more bytes of the attempt have been taken is ignored. There is no `col_pulse`, no retry, and the whole frame goes out.
- R5: After the jam of a non-final collision, `retry_pulse` is high for one cycle. The source rewinds, and the next attempt begins again with the frame's first byte.
- R6: After the n-th collision, the time from `retry_pulse` to the next rise of `tx_en` is at least `IPG_BYTES` cycles. It is at most (2^min(n,`BO_CAP`)-1)·`SLOT_BYTES` + `IPG_BYTES` + 6 cycles.
- R7: On the `MAX_ATT`-th (16th) collision of a frame, the jam is sent and no retry follows. The frame ends with status code 4 (excessive).
- R8: Each frame ends with `done` high for exactly one cycle, never together with `retry_pulse`. `done_code` is then 0 for clean, 1 for deferred (carrier seen while the first attempt was ready and no collision), 2 for one collision, 3 for more than one collision, or 4 for excessive.
- R9: With `full_duplex` high, `crs` and `col` are ignored. The frame starts despite carrier, no `col_pulse` is raised, and the code is 0.
- R10: While in reset, `tx_en`, `in_ready`, `col_pulse`, `retry_pulse` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | High selects full duplex, which ignores carrier and collision |
| cell_thresh | input | CELL_W | Start threshold in 64-byte cells |
| fifo_cells | input | CELL_W | Cells currently held by the FIFO |
| pkt_complete | input | 1 | FIFO holds a whole packet |
| in_valid | input | 1 | Frame byte available |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Current byte is the frame's last |
| in_ready | output | 1 | Byte taken this cycle |
| crs | input | 1 | Carrier sense from PHY |
| col | input | 1 | Collision from PHY |
| tx_en | output | 1 | Transmit enable to PHY |
| tx_data | output | 8 | Transmit byte to PHY |
| col_pulse | output | 1 | Early collision detected |
| retry_pulse | output | 1 | Rewind frame and retry |
| done | output | 1 | Frame finished or aborted |
| done_code | output | 3 | Frame class, valid with done |

## Verification
The hardest situation to reach is a frame whose sixteen attempts all collide inside the first slot, each followed by its own random back-off. Getting there takes collisions timed against the byte intake of every attempt. The bench keeps a per-attempt collision plan keyed on the number of bytes the block has taken, and fires `col` the cycle after the chosen byte is accepted. It builds the block with an 8-byte slot and a back-off cap of 4, so sixteen back-offs stay short. Late collisions, full-duplex frames and carrier deferral are mixed into random frames under the same plan.

// File: rtl/hdx_txc_pkg.sv
package hdx_txc_pkg;

   typedef enum logic [1:0] {
      ST_WAIT    = 2'd0,
      ST_TX      = 2'd1,
      ST_JAM     = 2'd2,
      ST_BACKOFF = 2'd3
   } txc_state_e;

   typedef enum logic [2:0] {
      TXS_OK     = 3'd0,
      TXS_DEFER  = 3'd1,
      TXS_SINGLE = 3'd2,
      TXS_MULTI  = 3'd3,
      TXS_EXCESS = 3'd4
   } txc_status_e;

endpackage

// File: rtl/hdx_txc_start_gate.sv
module hdx_txc_start_gate #(
   parameter int CELL_W = 8
) (
   input  logic [CELL_W-1:0] cell_thresh,
   input  logic [CELL_W-1:0] fifo_cells,
   input  logic              pkt_complete,
   output logic              start_ok
);
   generate
      if (CELL_W < 1) begin : g_bad_w
         $error("hdx_txc_start_gate: CELL_W must be at least 1");
      end
   endgenerate

   // a whole packet or enough cells lets the first attempt go
   always_comb begin
      start_ok = pkt_complete || (fifo_cells >= cell_thresh);
   end
endmodule

// File: rtl/hdx_txc_gap_timer.sv
module hdx_txc_gap_timer #(
   parameter int IPG_BYTES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic quiet,
   output logic gap_ok
);
   localparam int GW = $clog2(IPG_BYTES + 1);

   generate
      if (IPG_BYTES < 1) begin : g_bad_ipg
         $error("hdx_txc_gap_timer: IPG_BYTES must be at least 1");
      end
   endgenerate

   logic [GW-1:0] quiet_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
      end else if (!quiet) begin
         quiet_cnt <= '0;
      end else if (quiet_cnt != GW'(IPG_BYTES)) begin
         quiet_cnt <= quiet_cnt + GW'(1);
      end
   end

   assign gap_ok = (quiet_cnt == GW'(IPG_BYTES));

   // R2: any busy cycle clears the gap
   p_gap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !quiet |=> !gap_ok);
endmodule

// File: rtl/hdx_txc_backoff.sv
module hdx_txc_backoff #(
   parameter int          SLOT_BYTES = 64,
   parameter int          BO_CAP     = 10,
   parameter int          ATT_W      = 5,
   parameter int          LFSR_W     = 16,
   parameter logic [31:0] LFSR_SEED  = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ATT_W-1:0] attempt,
   output logic             busy
);
   localparam int SC_W = $clog2(SLOT_BYTES);

   generate
      if (BO_CAP < 1 || BO_CAP > LFSR_W) begin : g_bad_cap
         $error("hdx_txc_backoff: BO_CAP must lie in 1..LFSR_W");
      end
      if (SLOT_BYTES < 2) begin : g_bad_slot
         $error("hdx_txc_backoff: SLOT_BYTES must be at least 2");
      end
   endgenerate

   logic [LFSR_W-1:0] lfsr;
   logic [BO_CAP-1:0] rnd;
   logic [BO_CAP-1:0] mask;
   logic [BO_CAP-1:0] slots_left;
   logic [SC_W-1:0]   sub_cnt;
   logic              active;

   // Galois LFSR, taps picked by width
   generate
      if (LFSR_W == 16) begin : g_lfsr16
         localparam logic [15:0] TAPS = 16'hB400;
         always_ff @(posedge clk) begin
            if (!rst_n) lfsr <= LFSR_SEED[15:0] | 16'h1;
            else        lfsr <= (lfsr >> 1) ^ (lfsr[0] ? TAPS : 16'h0);
         end
      end else if (LFSR_W == 32) begin : g_lfsr32
         localparam logic [31:0] TAPS = 32'h8020_0003;
         always_ff @(posedge clk) begin
            if (!rst_n) lfsr <= LFSR_SEED | 32'h1;
            else        lfsr <= (lfsr >> 1) ^ (lfsr[0] ? TAPS : 32'h0);
         end
      end else begin : g_lfsr_bad
         $error("hdx_txc_backoff: LFSR_W must be 16 or 32");
      end
   endgenerate

   // fold every LFSR bit into the draw; window = min(n, cap) low bits
   always_comb begin
      rnd  = '0;
      mask = '0;
      for (int i = 0; i < LFSR_W; i++) rnd[i % BO_CAP] = rnd[i % BO_CAP] ^ lfsr[i];
      for (int i = 0; i < BO_CAP; i++) if (int'(attempt) > i) mask[i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         slots_left <= '0;
         sub_cnt    <= '0;
      end else if (start) begin
         active     <= 1'b1;
         slots_left <= rnd & mask;
         sub_cnt    <= '0;
      end else if (active) begin
         if (slots_left == '0) begin
            active <= 1'b0;
         end else if (sub_cnt == SC_W'(SLOT_BYTES - 1)) begin
            sub_cnt    <= '0;
            slots_left <= slots_left - BO_CAP'(1);
         end else begin
            sub_cnt <= sub_cnt + SC_W'(1);
         end
      end
   end

   assign busy = active;

   // R6: the drawn slot count never exceeds the window for this attempt
   p_bo_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((slots_left & ~$past(mask)) == '0));
endmodule

// File: rtl/hdx_tx_ctrl.sv
module hdx_tx_ctrl
   import hdx_txc_pkg::*;
#(
   parameter int          CELL_W     = 8,
   parameter int          SLOT_BYTES = 64,
   parameter int          IPG_BYTES  = 12,
   parameter int          JAM_BITS   = 32,
   parameter logic [7:0]  JAM_BYTE   = 8'h55,
   parameter int          BO_CAP     = 10,
   parameter int          MAX_ATT    = 16,
   parameter int          LFSR_W     = 16,
   parameter logic [31:0] LFSR_SEED  = 32'h0000_ACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_duplex,
   input  logic [CELL_W-1:0] cell_thresh,
   input  logic [CELL_W-1:0] fifo_cells,
   input  logic              pkt_complete,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   input  logic              crs,
   input  logic              col,
   output logic              tx_en,
   output logic [7:0]        tx_data,
   output logic              col_pulse,
   output logic              retry_pulse,
   output logic              done,
   output logic [2:0]        done_code
);
   localparam int JAM_BYTES = JAM_BITS / 8;
   localparam int BC_W      = $clog2(SLOT_BYTES + 1);
   localparam int AC_W      = $clog2(MAX_ATT + 1);
   localparam int JC_W      = (JAM_BYTES > 1) ? $clog2(JAM_BYTES) : 1;

   generate
      if ((JAM_BITS % 8) != 0 || JAM_BYTES < 2) begin : g_bad_jam
         $error("hdx_tx_ctrl: JAM_BITS must be a multiple of 8, at least 16");
      end
      if (MAX_ATT < 2) begin : g_bad_att
         $error("hdx_tx_ctrl: MAX_ATT must be at least 2");
      end
   endgenerate

   txc_state_e      state;
   logic [BC_W-1:0] byte_cnt;
   logic [AC_W-1:0] coll_n;
   logic [JC_W-1:0] jam_cnt;
   logic            retrying;
   logic            deferred;

   logic crs_eff, col_eff, early_col, late_col, accept, quiet;
   logic start_ok, gap_ok, go, jam_end, final_col, bo_start, bo_busy;
   logic frame_ok, abort;
   txc_status_e code_d;

   // full duplex masks both sensing inputs
   assign crs_eff   = crs & ~full_duplex;
   assign col_eff   = col & ~full_duplex;
   assign early_col = (state == ST_TX) && col_eff && (byte_cnt <  BC_W'(SLOT_BYTES));
   assign late_col  = (state == ST_TX) && col_eff && (byte_cnt >= BC_W'(SLOT_BYTES));
   assign accept    = (state == ST_TX) && in_valid && !early_col;
   assign in_ready  = accept;
   assign quiet     = !tx_en && !crs_eff;
   assign go        = (state == ST_WAIT) && in_valid && gap_ok && (retrying || start_ok);
   assign jam_end   = (state == ST_JAM) && (jam_cnt == JC_W'(JAM_BYTES - 1));
   assign final_col = (coll_n == AC_W'(MAX_ATT));
   assign bo_start  = jam_end && !final_col;
   assign abort     = jam_end && final_col;
   assign frame_ok  = accept && in_last;

   always_comb begin
      if (abort)                     code_d = TXS_EXCESS;
      else if (coll_n == '0)         code_d = deferred ? TXS_DEFER : TXS_OK;
      else if (coll_n == AC_W'(1))   code_d = TXS_SINGLE;
      else                           code_d = TXS_MULTI;
   end

   hdx_txc_start_gate #(.CELL_W(CELL_W)) u_gate (
      .cell_thresh  (cell_thresh),
      .fifo_cells   (fifo_cells),
      .pkt_complete (pkt_complete),
      .start_ok     (start_ok)
   );

   hdx_txc_gap_timer #(.IPG_BYTES(IPG_BYTES)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .quiet  (quiet),
      .gap_ok (gap_ok)
   );

   hdx_txc_backoff #(
      .SLOT_BYTES (SLOT_BYTES),
      .BO_CAP     (BO_CAP),
      .ATT_W      (AC_W),
      .LFSR_W     (LFSR_W),
      .LFSR_SEED  (LFSR_SEED)
   ) u_bo (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bo_start),
      .attempt (coll_n),
      .busy    (bo_busy)
   );

   // attempt sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_WAIT;
         byte_cnt <= '0;
         coll_n   <= '0;
         jam_cnt  <= '0;
         retrying <= 1'b0;
         deferred <= 1'b0;
      end else begin
         unique case (state)
            ST_WAIT: begin
               if (!retrying && in_valid && start_ok && crs_eff) deferred <= 1'b1;
               if (go) begin
                  state    <= ST_TX;
                  byte_cnt <= '0;
               end
            end
            ST_TX: begin
               if (early_col) begin
                  state   <= ST_JAM;
                  jam_cnt <= JC_W'(1);
                  coll_n  <= coll_n + AC_W'(1);
               end else if (accept) begin
                  if (byte_cnt != BC_W'(SLOT_BYTES)) byte_cnt <= byte_cnt + BC_W'(1);
                  if (in_last) begin
                     state    <= ST_WAIT;
                     coll_n   <= '0;
                     retrying <= 1'b0;
                     deferred <= 1'b0;
                  end
               end
            end
            ST_JAM: begin
               jam_cnt <= jam_cnt + JC_W'(1);
               if (jam_end) begin
                  if (final_col) begin
                     state    <= ST_WAIT;
                     coll_n   <= '0;
                     retrying <= 1'b0;
                     deferred <= 1'b0;
                  end else begin
                     state    <= ST_BACKOFF;
                     retrying <= 1'b1;
                  end
               end
            end
            ST_BACKOFF: begin
               if (!bo_busy) state <= ST_WAIT;
            end
            default: state <= ST_WAIT;
         endcase
      end
   end

   // registered PHY side and status
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en       <= 1'b0;
         tx_data     <= '0;
         col_pulse   <= 1'b0;
         retry_pulse <= 1'b0;
         done        <= 1'b0;
         done_code   <= '0;
      end else begin
         tx_en       <= accept || early_col || (state == ST_JAM);
         tx_data     <= accept ? in_data : JAM_BYTE;
         col_pulse   <= early_col;
         retry_pulse <= bo_start;
         done        <= frame_ok || abort;
         done_code   <= code_d;
      end
   end

   // R1: a first attempt never starts without the gate
   p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !retrying && !start_ok) |=> (state != ST_TX));
   // R3: collision report coincides with a jam byte on the line
   p_col_jam_r3: assert property (@(posedge clk) disable iff (!rst_n)
      col_pulse |-> (tx_en && tx_data == JAM_BYTE));
   // R4: a late collision leads to no jam
   p_late_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      late_col |=> (state != ST_JAM && !col_pulse));
   // R5: retry is issued together with the final jam byte
   p_retry_after_jam_r5: assert property (@(posedge clk) disable iff (!rst_n)
      retry_pulse |-> (tx_en && tx_data == JAM_BYTE && $past(state) == ST_JAM));
   // R6: nothing is taken during back-off
   p_backoff_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BACKOFF) |-> !in_ready);
   // R7: excessive status only after the last allowed collision
   p_excess_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_code == TXS_EXCESS) |-> ($past(coll_n) == AC_W'(MAX_ATT)));
   // R8: end of frame and retry never coincide
   p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, retry_pulse}));
   // R9: full duplex raises no collision
   p_fd_no_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full_duplex && $past(full_duplex)) |-> !col_pulse);
endmodule

// File: tb/hdx_tx_ctrl_test.sv
`timescale 1ns/1ps
module hdx_tx_ctrl_test;
   localparam int SLOT  = 8;
   localparam int IPG   = 12;
   localparam int CAP   = 4;
   localparam int MAXA  = 16;
   localparam logic [7:0] JAMB = 8'h55;

   logic clk = 1'b0, rst_n = 1'b0;
   logic full_duplex = 1'b0, pkt_complete = 1'b1;
   logic [7:0] cell_thresh = 8'd1, fifo_cells = 8'd0;
   logic in_valid = 1'b0, in_last = 1'b0, crs = 1'b0, col = 1'b0;
   logic [7:0] in_data = 8'd0;
   logic in_ready, tx_en, col_pulse, retry_pulse, done;
   logic [7:0] tx_data;
   logic [2:0] done_code;

   always #2 clk = ~clk;

   hdx_tx_ctrl #(.SLOT_BYTES(SLOT), .IPG_BYTES(IPG), .BO_CAP(CAP), .MAX_ATT(MAXA)) uut (
      .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .cell_thresh(cell_thresh),
      .fifo_cells(fifo_cells), .pkt_complete(pkt_complete), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .crs(crs), .col(col),
      .tx_en(tx_en), .tx_data(tx_data), .col_pulse(col_pulse), .retry_pulse(retry_pulse),
      .done(done), .done_code(done_code));

   int checks = 0, errs = 0, cyc = 0;
   bit wd = 0;
   int plan [0:19];
   int len, idx, att, nb, jb, colp, rets, t_retry, first_rise;
   bit active = 0, acc = 0, prev_tx = 0, got_done = 0;
   logic [2:0] got_code;

   function automatic logic [7:0] bval(int i);
      return 8'(8'h80 + (i & 63));
   endfunction

   function automatic int exp_code(int ncol, bit fd, bit def);
      if (fd)           return 0;
      if (ncol >= MAXA) return 4;
      if (ncol == 0)    return def ? 1 : 0;
      if (ncol == 1)    return 2;
      return 3;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      if (cyc > 150000) wd = 1;
      if (tx_en && !prev_tx) begin
         if (first_rise < 0) first_rise = cyc;
         if (att > 0 && !full_duplex) begin
            int k = (att < CAP) ? att : CAP;
            int hi = ((1 << k) - 1) * SLOT + IPG + 6;
            chk(cyc - t_retry >= IPG && cyc - t_retry <= hi, "R6 backoff window", cyc - t_retry, hi);
            chk(tx_data == bval(0), "R5 retry restarts at byte 0", tx_data, bval(0));
         end
      end
      if (tx_en) nb++;
      if (tx_en && tx_data == JAMB) jb++;
      prev_tx = tx_en;
      if (col_pulse) colp++;
      if (acc) idx++;
      if (retry_pulse) begin
         chk(nb == plan[att] + 4, "R3 attempt bytes before retry", nb, plan[att] + 4);
         chk(jb == 4, "R3 jam byte count", jb, 4);
         rets++; att++; idx = 0; nb = 0; jb = 0; t_retry = cyc;
      end
      if (done) begin
         got_done = 1; got_code = done_code; active = 0;
      end
      col = 1'b0;
      if (active && acc && plan[att] >= 0 && idx == plan[att]) col = 1'b1;
      in_valid = active;
      in_data  = bval(idx);
      in_last  = active && (idx == len - 1);
      #1 acc = in_ready;
   endtask

   task automatic run_frame(int flen, int ncol, int late, bit fd, int defer_cyc, int gate_hold);
      int crs_fall = -1;
      int eff;
      bit def = (defer_cyc > 0);
      full_duplex = fd;
      for (int a = 0; a < 20; a++) plan[a] = -1;
      for (int a = 0; a < ncol && a < MAXA; a++) plan[a] = 1 + int'($urandom % (SLOT - 1));
      if (late > 0 && ncol < MAXA) plan[ncol] = late;
      len = flen; idx = 0; att = 0; nb = 0; jb = 0; colp = 0; rets = 0;
      first_rise = -1; got_done = 0; acc = 0;
      if (gate_hold > 0) begin
         pkt_complete = 1'b0; cell_thresh = 8'd3; fifo_cells = 8'd2;
      end
      crs = def;
      active = 1;
      for (int n = 0; n < gate_hold && !wd; n++) step();
      if (gate_hold > 0) begin
         chk(nb == 0, "R1 no start below cell threshold", nb, 0);
         fifo_cells = 8'd3;
      end
      for (int n = 0; n < 20000 && !got_done && !wd; n++) begin
         if (def && n == defer_cyc) begin crs = 1'b0; crs_fall = cyc; end
         step();
      end
      crs = 1'b0;
      eff = fd ? 0 : ((ncol > MAXA) ? MAXA : ncol);
      chk(got_done, "R8 done seen", got_done, 1);
      chk(int'(got_code) == exp_code(eff, fd, def), "R8 status code", got_code, exp_code(eff, fd, def));
      if (late > 0) chk(colp == eff, "R4 late collision not counted", colp, eff);
      else          chk(colp == eff, "R3 collision pulses", colp, eff);
      chk(rets == ((eff >= MAXA) ? MAXA - 1 : eff), "R5 retry count", rets, (eff >= MAXA) ? MAXA - 1 : eff);
      if (eff >= MAXA) begin
         chk(nb == plan[MAXA-1] + 4, "R7 final attempt jams and stops", nb, plan[MAXA-1] + 4);
      end else begin
         chk(nb == flen, "R4 final attempt sends whole frame", nb, flen);
      end
      if (def && !fd) chk(first_rise - crs_fall >= IPG, "R2 gap after carrier", first_rise - crs_fall, IPG);
      if (def && fd)  chk(first_rise >= 0 && first_rise < crs_fall, "R9 start under carrier", first_rise, crs_fall);
      if (fd && ncol > 0) chk(colp == 0, "R9 collision ignored", colp, 0);
      pkt_complete = 1'b1; cell_thresh = 8'd1; fifo_cells = 8'd0; full_duplex = 1'b0;
      active = 0;
      for (int n = 0; n < 3; n++) step();
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int a = 0; a < 20; a++) plan[a] = -1;
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk(!tx_en && !in_ready && !done && !col_pulse && !retry_pulse, "R10 reset outputs",
          {tx_en, in_ready, done, col_pulse, retry_pulse}, 0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      for (int n = 0; n < 2; n++) step();

      run_frame(12, 0, 0, 0, 0, 40);     // R1 threshold gating
      run_frame(10, 0, 0, 0, 0, 0);      // clean, whole-packet start
      run_frame(14, 1, 0, 0, 0, 0);      // R3 single collision
      run_frame(20, 3, 0, 0, 0, 0);      // multiple
      run_frame(20, 0, 12, 0, 0, 0);     // R4 late only
      run_frame(24, 2, 15, 0, 0, 0);     // early then late
      run_frame(16, 0, 0, 0, 20, 0);     // R2/R8 deferral
      run_frame(16, 0, 0, 1, 20, 0);     // R9 carrier in full duplex
      run_frame(16, 3, 0, 1, 0, 0);      // R9 collisions in full duplex
      run_frame(18, MAXA, 0, 0, 0, 0);   // R7 excessive
      run_frame(12, MAXA - 1, 0, 0, 0, 0); // one short of excessive

      for (int f = 0; f < 24 && !wd; f++) begin
         int fl = 9 + int'($urandom % 32);
         int nc = int'($urandom % 4);
         int lt = 0;
         bit fd = (($urandom % 4) == 0);
         int dc = (($urandom % 5) == 0) ? 5 + int'($urandom % 10) : 0;
         if (fl > SLOT + 1 && ($urandom % 2) == 1) lt = SLOT + int'($urandom % (fl - SLOT));
         run_frame(fl, nc, lt, fd, dc, 0);
      end

      if (wd) chk(0, "watchdog expired", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule